// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status Unit

This block watches a vector of general-purpose input pins and turns chosen changes or levels on them into a single interrupt request. Each pin is set up on its own through a set of per-line bit registers. One register picks level or edge sensing. One picks the polarity. One turns on detection of both edges. Pins first pass through a two-stage synchronizer. An event that is detected on an enabled line sets a latched status bit, and that bit stays set until software acknowledges it by writing a one to its position in the clear register.

Software reads the status in two forms: raw, and with the per-line mask applied. The interrupt output is high whenever any unmasked status bit is set. Access is through a plain register port with an address, write data, a write strobe and combinational read data. Driving pins, choosing direction and filtering bounce are left to other blocks.

Top module: `pin_event_irq`

## Requirements
- R1: After reset, every register reads 0 and `irq_out` is 0.
- R2: The enable (0x20), mask (0x2C), type (0x34), both-edge (0x38) and polarity (0x3C) registers read back the full word last written to them. The clear address (0x30) and any address not listed here read 0.
- R3: A line with type bit 1 is level sensitive. With polarity bit 0 it is active when the sampled pin is 1. With polarity bit 1 it is active when the sampled pin is 0. While it is enabled and active, its raw status bit is set.
- R4: A line with type bit 0 is edge sensitive. Polarity bit 0 selects a rising edge and polarity bit 1 selects a falling edge. When the both-edge bit is 1, either edge sets status and the polarity bit has no effect.
- R5: Writing to the clear address clears the raw status bits written as 1 and leaves the bits written as 0 unchanged. Raw status bits are never cleared in any other way.
- R6: Events are detected only on lines whose enable bit is 1. Status that has already latched stays set when the line is disabled.
- R7: Masked status (0x28) equals raw status (0x24) AND NOT mask. `irq_out` is the OR of all masked status bits.
- R8: A pin change that is driven before a rising clock edge is visible in raw status after the third rising edge, counting that edge as the first, and not before.
- R9: A level-sensitive line that is still active when it is cleared reads 1 in raw status in the cycle after the clear. A detected event wins over a clear in the same cycle.
- R10: Writes to the raw status and masked status addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data, one bit per line |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pins_in | input | 32 | Asynchronous pin inputs |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 32 lines and an 8-bit address. This means the top line, bit 31, is tested in the same width that real software sees, and every register address is decoded in full. With a full-width word, the read-back patterns cover both halves of every register. An edge on the highest pin shows that no bit is lost at the top of the vector.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

  localparam logic [7:0] OFS_ENABLE = 8'h20;
  localparam logic [7:0] OFS_RAW    = 8'h24;
  localparam logic [7:0] OFS_MASKED = 8'h28;
  localparam logic [7:0] OFS_MASK   = 8'h2C;
  localparam logic [7:0] OFS_CLEAR  = 8'h30;
  localparam logic [7:0] OFS_TYPE   = 8'h34;
  localparam logic [7:0] OFS_BOTH   = 8'h38;
  localparam logic [7:0] OFS_POLAR  = 8'h3C;

  typedef struct packed {
    logic is_level;
    logic active_low;
    logic any_edge;
  } line_mode_t;

  function automatic logic line_fires(input logic cur, input logic prev,
                                      input line_mode_t m);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (m.is_level)
      return m.active_low ? ~cur : cur;
    else if (m.any_edge)
      return rise | fall;
    else
      return m.active_low ? fall : rise;
  endfunction

  function automatic logic [31:0] next_status(input logic [31:0] raw,
                                              input logic [31:0] clr,
                                              input logic [31:0] evt,
                                              input logic [31:0] en);
    return (raw & ~clr) | (evt & en);
  endfunction

endpackage

// File: rtl/pin_event_sync.sv
module pin_event_sync #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pins_in,
  output logic [NUM_LINES-1:0] cur_o,
  output logic [NUM_LINES-1:0] prev_o
);
  logic [NUM_LINES-1:0] stage1_q;
  logic [NUM_LINES-1:0] stage2_q;
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pins_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign cur_o  = stage2_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
  import pin_event_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic [NUM_LINES-1:0] cur_i,
  input  logic [NUM_LINES-1:0] prev_i,
  input  logic [NUM_LINES-1:0] type_i,
  input  logic [NUM_LINES-1:0] polar_i,
  input  logic [NUM_LINES-1:0] both_i,
  output logic [NUM_LINES-1:0] evt_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_mode_t mode;
    assign mode.is_level   = type_i[g];
    assign mode.active_low = polar_i[g];
    assign mode.any_edge   = both_i[g];
    assign evt_o[g] = line_fires(cur_i[g], prev_i[g], mode);
  end
endmodule

// File: rtl/pin_event_regs.sv
module pin_event_regs
  import pin_event_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  input  logic                 we_i,
  input  logic [NUM_LINES-1:0] evt_i,
  output logic [NUM_LINES-1:0] rdata_o,
  output logic [NUM_LINES-1:0] en_o,
  output logic [NUM_LINES-1:0] type_o,
  output logic [NUM_LINES-1:0] polar_o,
  output logic [NUM_LINES-1:0] both_o,
  output logic [NUM_LINES-1:0] raw_o,
  output logic [NUM_LINES-1:0] masked_o
);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_TYPE   = ADDR_W'(OFS_TYPE);
  localparam logic [ADDR_W-1:0] A_BOTH   = ADDR_W'(OFS_BOTH);
  localparam logic [ADDR_W-1:0] A_POLAR  = ADDR_W'(OFS_POLAR);

  logic [NUM_LINES-1:0] en_q, mask_q, type_q, polar_q, both_q, raw_q;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] raw_next;

  assign clr_vec  = (we_i && addr_i == A_CLEAR) ? wdata_i : '0;
  assign raw_next = NUM_LINES'(next_status(32'(raw_q), 32'(clr_vec),
                                           32'(evt_i), 32'(en_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '0;
      type_q  <= '0;
      polar_q <= '0;
      both_q  <= '0;
      raw_q   <= '0;
    end else begin
      raw_q <= raw_next;
      if (we_i) begin
        case (addr_i)
          A_ENABLE: en_q    <= wdata_i;
          A_MASK:   mask_q  <= wdata_i;
          A_TYPE:   type_q  <= wdata_i;
          A_BOTH:   both_q  <= wdata_i;
          A_POLAR:  polar_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign masked_o = raw_q & ~mask_q;

  always_comb begin
    case (addr_i)
      A_ENABLE: rdata_o = en_q;
      A_RAW:    rdata_o = raw_q;
      A_MASKED: rdata_o = masked_o;
      A_MASK:   rdata_o = mask_q;
      A_TYPE:   rdata_o = type_q;
      A_BOTH:   rdata_o = both_q;
      A_POLAR:  rdata_o = polar_q;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign type_o  = type_q;
  assign polar_o = polar_q;
  assign both_o  = both_q;
  assign raw_o   = raw_q;

  // R5: a raw bit only falls after a one was written to its clear position
  assert_fall_needs_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(raw_q) & ~raw_q & ~$past(clr_vec)) == '0));

  // R6: a disabled line never gains a status bit
  assert_disabled_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(en_q)) == '0));

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [NUM_LINES-1:0] reg_wdata,
  input  logic                 reg_we,
  output logic [NUM_LINES-1:0] reg_rdata,
  input  logic [NUM_LINES-1:0] pins_in,
  output logic                 irq_out
);
  logic [NUM_LINES-1:0] samp_cur, samp_prev;
  logic [NUM_LINES-1:0] cfg_en, cfg_type, cfg_polar, cfg_both;
  logic [NUM_LINES-1:0] line_evt, stat_raw, stat_masked;

  pin_event_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_in(pins_in),
    .cur_o  (samp_cur),
    .prev_o (samp_prev)
  );

  pin_event_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .cur_i  (samp_cur),
    .prev_i (samp_prev),
    .type_i (cfg_type),
    .polar_i(cfg_polar),
    .both_i (cfg_both),
    .evt_o  (line_evt)
  );

  pin_event_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .we_i    (reg_we),
    .evt_i   (line_evt),
    .rdata_o (reg_rdata),
    .en_o    (cfg_en),
    .type_o  (cfg_type),
    .polar_o (cfg_polar),
    .both_o  (cfg_both),
    .raw_o   (stat_raw),
    .masked_o(stat_masked)
  );

  assign irq_out = |stat_masked;

  // R3: an enabled, active level line is latched on the next edge
  assert_level_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cfg_en & cfg_type & (samp_cur ^ cfg_polar)) & ~stat_raw) == '0));

  // R4: in both-edge mode any change of the sampled pin is latched
  assert_both_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cfg_en & ~cfg_type & cfg_both & (samp_cur ^ samp_prev)) & ~stat_raw) == '0));

  // R7: the request is only raised when some raw status bit is set
  assert_irq_needs_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (stat_raw != '0));

endmodule

// File: tb/pin_event_irq_bench.sv
module pin_event_irq_bench;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [N-1:0]  reg_wdata = '0;
  logic          reg_we = 1'b0;
  logic [N-1:0]  reg_rdata;
  logic [N-1:0]  pins = '0;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pin_event_irq #(.NUM_LINES(N), .ADDR_W(8)) u_pin_event_irq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .pins_in(pins), .irq_out(irq_out)
  );

  // Reference model: pin history and register state kept as plain words
  logic [N-1:0] h1 = '0, h2 = '0, h3 = '0;
  logic [N-1:0] m_en = '0, m_mask = '0, m_type = '0, m_pol = '0, m_both = '0, m_raw = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = '0; h2 = '0; h3 = '0;
      m_en = '0; m_mask = '0; m_type = '0; m_pol = '0; m_both = '0; m_raw = '0;
    end else begin
      logic [N-1:0] hit;
      for (int i = 0; i < N; i++) begin
        int now_v, old_v;
        now_v = h2[i];
        old_v = h3[i];
        if (m_type[i]) hit[i] = (now_v != m_pol[i]);
        else if (m_both[i]) hit[i] = (now_v != old_v);
        else if (m_pol[i]) hit[i] = (now_v == 0 && old_v == 1);
        else hit[i] = (now_v == 1 && old_v == 0);
      end
      for (int i = 0; i < N; i++) begin
        if (reg_we && reg_addr == 8'h30 && reg_wdata[i]) m_raw[i] = 1'b0;
        if (hit[i] && m_en[i]) m_raw[i] = 1'b1;
      end
      if (reg_we) begin
        if (reg_addr == 8'h20) m_en = reg_wdata;
        if (reg_addr == 8'h2C) m_mask = reg_wdata;
        if (reg_addr == 8'h34) m_type = reg_wdata;
        if (reg_addr == 8'h38) m_both = reg_wdata;
        if (reg_addr == 8'h3C) m_pol = reg_wdata;
      end
      h3 = h2; h2 = h1; h1 = pins;
    end
  end

  function automatic logic [N-1:0] model_read(input logic [7:0] a);
    case (a)
      8'h20: return m_en;
      8'h24: return m_raw;
      8'h28: return m_raw & ~m_mask;
      8'h2C: return m_mask;
      8'h34: return m_type;
      8'h38: return m_both;
      8'h3C: return m_pol;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    #3;
    if (rst_n && !finished) begin
      check("R7 irq_out vs model", N'(irq_out), N'(|(m_raw & ~m_mask)));
      check("R2 read data vs model", reg_rdata, model_read(reg_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [N-1:0] exp);
    logic [N-1:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    pins[i] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      summary();
    end
  end

  initial begin
    logic [N-1:0] v;
    idle(3);
    // R1: reset state
    check("R1 irq after reset", N'(irq_out), '0);
    rd_check("R1 raw after reset", 8'h24, '0);
    rd_check("R1 enable after reset", 8'h20, '0);
    rst_n = 1'b1;
    idle(2);
    rd_check("R1 type after release", 8'h34, '0);

    // R2: read-back, with all lines disabled
    wr(8'h2C, 32'h1234_5678); rd_check("R2 mask readback", 8'h2C, 32'h1234_5678);
    wr(8'h34, 32'hA5A5_5A5A); rd_check("R2 type readback", 8'h34, 32'hA5A5_5A5A);
    wr(8'h38, 32'hFFFF_0000); rd_check("R2 both readback", 8'h38, 32'hFFFF_0000);
    wr(8'h3C, 32'h0F0F_F0F0); rd_check("R2 polarity readback", 8'h3C, 32'h0F0F_F0F0);
    wr(8'h20, 32'h8000_0001); rd_check("R2 enable readback", 8'h20, 32'h8000_0001);
    rd_check("R2 clear address reads 0", 8'h30, '0);
    rd_check("R2 unused address reads 0", 8'h40, '0);
    wr(8'h20, '0); wr(8'h2C, '0); wr(8'h34, '0); wr(8'h38, '0); wr(8'h3C, '0);
    wr(8'h30, '1);
    idle(2);
    rd_check("R5 raw empty after full clear", 8'h24, '0);

    // R8 and R4 rising: exact latency on line 0
    wr(8'h20, '1);
    idle(2);
    set_pin(0, 1'b1);
    @(negedge clk);
    rd_check("R8 raw not yet set after two edges", 8'h24, '0);
    rd_check("R8 R4 raw set after third edge", 8'h24, 32'h0000_0001);
    check("R7 irq high with unmasked status", N'(irq_out), N'(1));

    // R5: zero write leaves status, one write clears it
    wr(8'h30, '0);
    rd_check("R5 zero clear keeps bit", 8'h24, 32'h0000_0001);
    wr(8'h30, 32'h0000_0001);
    rd_check("R5 one clear drops bit", 8'h24, '0);

    // R4 falling on line 5
    wr(8'h3C, 32'h0000_0020);
    set_pin(5, 1'b1); idle(5);
    rd_check("R4 rising ignored in falling mode", 8'h24, '0);
    set_pin(5, 1'b0); idle(5);
    rd_check("R4 falling edge latched", 8'h24, 32'h0000_0020);
    wr(8'h30, '1);

    // R4 both edges on line 9, polarity bit set but ignored
    wr(8'h38, 32'h0000_0200);
    wr(8'h3C, 32'h0000_0220);
    set_pin(9, 1'b1); idle(5);
    rd_check("R4 both-edge rise", 8'h24, 32'h0000_0200);
    wr(8'h30, '1);
    set_pin(9, 1'b0); idle(5);
    rd_check("R4 both-edge fall", 8'h24, 32'h0000_0200);
    wr(8'h30, '1);

    // R3 and R9: level lines
    wr(8'h34, 32'h0000_1000);
    set_pin(12, 1'b1); idle(5);
    rd_check("R3 active-high level latched", 8'h24, 32'h0000_1000);
    wr(8'h30, 32'h0000_1000);
    rd_check("R9 active level re-sets after clear", 8'h24, 32'h0000_1000);
    set_pin(12, 1'b0); idle(4);
    wr(8'h30, '1);
    rd_check("R3 inactive level stays clear", 8'h24, '0);
    wr(8'h34, 32'h0000_3000);
    wr(8'h3C, 32'h0000_2220);
    idle(2);
    rd_check("R3 active-low level latched", 8'h24, 32'h0000_2000);
    set_pin(13, 1'b1); idle(4);
    wr(8'h30, '1);
    rd_check("R3 released active-low clears", 8'h24, '0);

    // R6: enable gating
    wr(8'h20, 32'hFFEF_FFFF);
    set_pin(20, 1'b1); idle(5);
    rd_check("R6 disabled line ignores edge", 8'h24, '0);
    wr(8'h20, '1);
    set_pin(21, 1'b1); idle(5);
    rd_check("R6 enabled line latches", 8'h24, 32'h0020_0000);
    wr(8'h20, '0);
    set_pin(22, 1'b1); idle(5);
    rd_check("R6 status kept after disable", 8'h24, 32'h0020_0000);

    // R7: masking
    wr(8'h2C, 32'h0020_0000);
    rd_check("R7 masked status hidden", 8'h28, '0);
    check("R7 irq low when masked", N'(irq_out), '0);
    rd_check("R7 raw unaffected by mask", 8'h24, 32'h0020_0000);
    wr(8'h2C, '0);
    rd_check("R7 masked status shown", 8'h28, 32'h0020_0000);

    // R10: status addresses ignore writes
    wr(8'h24, '0);
    wr(8'h28, '0);
    rd_check("R10 raw unchanged by write", 8'h24, 32'h0020_0000);
    wr(8'h30, 32'h0020_0000);
    check("R5 irq low after clear", N'(irq_out), '0);

    // Top line
    wr(8'h20, '1);
    set_pin(31, 1'b1); idle(5);
    rd_check("R4 top line rising edge", 8'h24, 32'h8000_0000);
    rd(8'h28, v);
    check("R7 masked top line", v, 32'h8000_0000);

    idle(3);
    summary();
  end
endmodule